// File: doc/BRIEF.md
# Boot Strap Sampler and Core Reset Sequencer

This block sits between the board-level reset pin and the processor core. While the active-low device reset is held low it keeps sampling a set of configuration straps: a 2-bit boot-mode code, an endian strap and a clock-mode strap. The value seen at the last clock edge with reset low is kept until the next reset. The latched endian and clock-mode straps are driven out directly. The boot-mode code is decoded into one of two boot flows.

The rest of the device leaves reset as soon as the pin goes high. The core does not. In host-port boot the core stays held until an external host writes a control word with its start bit set. In each ROM boot the block sends a one-cycle start request to the copy engine, together with the access width. It releases the core when the engine reports that the copy is done. No strap code releases the core without a boot. Once released, the core fetches from address zero; that part is the core's own behaviour and is not modelled here. The core stays released until the next device reset.

Top module: `boot_seq_top`

## Requirements
- R1: From the first clock edge at which `rst_pin_n` is sampled low, and for as long as it stays low, `core_rst_n` is 0 and `copy_start` is 0.
- R2: The straps are captured at every clock edge where `rst_pin_n` is low and held unchanged while it stays high. `endian_le` gives the captured endian strap (0 = big endian, 1 = little endian). `pll_mul4` gives the captured clock-mode strap (0 = no multiplication, 1 = multiply by 4).
- R3: The captured mode code selects the boot flow: 2'b00 host-port boot, 2'b01 8-bit ROM boot, 2'b10 16-bit ROM boot, 2'b11 32-bit ROM boot. `copy_width` gives log2 of the bytes per ROM access: 2'b00, 2'b01 and 2'b10 for the three ROM modes, and 2'b11 in host-port mode.
- R4: In a ROM mode, `copy_start` is high for exactly one cycle. That cycle follows the first clock edge at which `rst_pin_n` is sampled high.
- R5: In host-port mode, `copy_start` is never asserted.
- R6: In a ROM mode, `core_rst_n` rises one cycle after an edge that samples `copy_done` = 1. This applies at any edge from the one that ends the `copy_start` cycle onward.
- R7: In host-port mode, `core_rst_n` rises one cycle after an edge that samples `host_wr` = 1 with `host_start_bit` = 1. This applies from the release edge onward. A host write with `host_start_bit` = 0 has no effect.
- R8: In a ROM mode, host writes have no effect on `core_rst_n`. In host-port mode, `copy_done` pulses have no effect on `core_rst_n`.
- R9: Once `core_rst_n` is 1, it stays 1 until `rst_pin_n` is driven low. A new reset samples the straps again and starts the whole sequence over.
- R10: No mode code releases the core without its boot event: with no qualifying event, `core_rst_n` stays 0 for as long as the reset pin stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Device reset pin, active low, sampled synchronously |
| strap_mode | input | 2 | Boot-mode strap code |
| strap_endian | input | 1 | Endian strap |
| strap_clkmul | input | 1 | Clock-mode strap |
| host_wr | input | 1 | Host control-register write strobe |
| host_start_bit | input | 1 | Start bit carried by the host write |
| copy_done | input | 1 | Completion pulse from the ROM copy engine |
| endian_le | output | 1 | Captured endian mode, 1 = little endian |
| pll_mul4 | output | 1 | Captured PLL multiplier select, 1 = multiply by 4 |
| copy_start | output | 1 | One-cycle start request to the copy engine |
| copy_width | output | 2 | log2 of bytes per ROM access, 2'b11 in host mode |
| core_rst_n | output | 1 | Core reset, active low, 0 holds the core |

## Verification
A wrong sequencer state shows up at the ports within one cycle of the event that should have moved it. A core released early or late appears on `core_rst_n` on the cycle after the qualifying edge. A missed or extra launch appears as a `copy_start` pulse that is absent, doubled, or present in host mode. A strap register that still follows its input after release changes `endian_le`, `pll_mul4` or `copy_width` on the first cycle after the straps move. For that reason the straps are scrambled right after each release edge. A flow that accepts the wrong event is exposed by driving the other mode's event for several cycles before the correct one, checking that the core stays held.

// File: rtl/boot_seq_pkg.sv
// Shared types for the boot strap sampler and core reset sequencer.
// Assumes a 2-bit boot-mode strap code.
package boot_seq_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        BOOT_HOST  = 2'b00,
        BOOT_ROM8  = 2'b01,
        BOOT_ROM16 = 2'b10,
        BOOT_ROM32 = 2'b11
    } boot_sel_e;

    typedef enum logic [1:0] {
        SEQ_LAUNCH    = 2'b00,
        SEQ_HOST_WAIT = 2'b01,
        SEQ_COPY_WAIT = 2'b10,
        SEQ_RUN       = 2'b11
    } seq_state_e;

    localparam logic [1:0] WIDTH_NONE = 2'b11;

endpackage

// File: rtl/strap_latch.sv
// Strap capture register. It loads its input on every clock edge at which
// the active-low reset is low and holds the value while reset is high.
// Assumes the straps are stable around the reset release edge.
module strap_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_pin_n,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] strap_q
);

    // Track straps during reset, freeze them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_pin_n) begin
            strap_q <= strap_in;
        end
    end

endmodule

// File: rtl/boot_mode_decode.sv
// Combinational decode of the captured boot-mode code into a flow select
// (host-port or ROM) and the ROM access width as log2 bytes.
// Assumes the code comes from the strap latch.
module boot_mode_decode
    import boot_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    output logic              is_host,
    output logic [1:0]        copy_width
);

    // Map each mode code to its flow and width.
    always_comb begin
        is_host    = 1'b0;
        copy_width = WIDTH_NONE;
        case (boot_sel_e'(mode_code))
            BOOT_HOST:  is_host    = 1'b1;
            BOOT_ROM8:  copy_width = 2'b00;
            BOOT_ROM16: copy_width = 2'b01;
            BOOT_ROM32: copy_width = 2'b10;
            default:    is_host    = 1'b1;
        endcase
    end

endmodule

// File: rtl/core_release_seq.sv
// Release sequencer. After reset it either launches the ROM copy (with a
// one-cycle start pulse) or waits for a host start write, then releases
// the core and stays released until the next reset.
// Assumes is_host is stable while rst_n is high.
module core_release_seq
    import boot_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_host,
    input  logic host_wr,
    input  logic host_start_bit,
    input  logic copy_done,
    output logic copy_start,
    output logic copy_busy,
    output logic core_rst_n
);

    seq_state_e state_q;
    logic       start_q;
    logic       host_go;

    // Host write with the start bit set.
    assign host_go = host_wr & host_start_bit;

    // Sequence state and start pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LAUNCH;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                SEQ_LAUNCH: begin
                    if (is_host) begin
                        state_q <= host_go ? SEQ_RUN : SEQ_HOST_WAIT;
                    end else begin
                        state_q <= SEQ_COPY_WAIT;
                        start_q <= 1'b1;
                    end
                end
                SEQ_HOST_WAIT: if (host_go)   state_q <= SEQ_RUN;
                SEQ_COPY_WAIT: if (copy_done) state_q <= SEQ_RUN;
                default:       state_q <= SEQ_RUN;
            endcase
        end
    end

    // Outputs decoded from registered state.
    assign copy_start = start_q;
    assign copy_busy  = (state_q == SEQ_COPY_WAIT);
    assign core_rst_n = (state_q == SEQ_RUN);

endmodule

// File: rtl/boot_seq_top.sv
// Top of the boot strap sampler and core reset sequencer. It captures the
// straps during device reset, decodes the boot mode and holds the core in
// reset until its boot event.
// Assumes rst_pin_n is already synchronised to clk.
module boot_seq_top
    import boot_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              strap_endian,
    input  logic              strap_clkmul,
    input  logic              host_wr,
    input  logic              host_start_bit,
    input  logic              copy_done,
    output logic              endian_le,
    output logic              pll_mul4,
    output logic              copy_start,
    output logic [1:0]        copy_width,
    output logic              core_rst_n
);

    localparam int STRAP_W = MODE_W + 2;

    logic [STRAP_W-1:0] straps_q;
    logic               is_host;
    logic               copy_busy;

    strap_latch #(.W(STRAP_W)) strap_i (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .strap_in  ({strap_mode, strap_endian, strap_clkmul}),
        .strap_q   (straps_q)
    );

    boot_mode_decode dec_i (
        .mode_code  (straps_q[STRAP_W-1 -: MODE_W]),
        .is_host    (is_host),
        .copy_width (copy_width)
    );

    core_release_seq seq_i (
        .clk            (clk),
        .rst_n          (rst_pin_n),
        .is_host        (is_host),
        .host_wr        (host_wr),
        .host_start_bit (host_start_bit),
        .copy_done      (copy_done),
        .copy_start     (copy_start),
        .copy_busy      (copy_busy),
        .core_rst_n     (core_rst_n)
    );

    assign endian_le = straps_q[1];
    assign pll_mul4  = straps_q[0];

endmodule

// File: rtl/boot_seq_chk.sv
// Assertion checker for boot_seq_top, attached by bind.
module boot_seq_chk (
    input logic       clk,
    input logic       rst_pin_n,
    input logic       host_wr,
    input logic       host_start_bit,
    input logic       copy_done,
    input logic       endian_le,
    input logic       pll_mul4,
    input logic       copy_start,
    input logic [1:0] copy_width,
    input logic       core_rst_n,
    input logic       is_host,
    input logic       copy_busy
);

    // R1
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        copy_start |-> !core_rst_n);

    // R2
    straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        rst_pin_n |=> ($stable(endian_le) && $stable(pll_mul4) && $stable(copy_width)));

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        copy_start |=> !copy_start);

    // R5
    host_no_copy_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        is_host |-> !copy_start);

    // R6
    rom_release_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!is_host && copy_busy && copy_done) |=> core_rst_n);

    // R7
    host_release_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (is_host && host_wr && host_start_bit) |=> core_rst_n);

    // R8
    host_ignore_done_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (is_host && !core_rst_n && !(host_wr && host_start_bit)) |=> !core_rst_n);

    // R8
    rom_ignore_host_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!is_host && !core_rst_n && !(copy_busy && copy_done)) |=> !core_rst_n);

    // R9
    release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        core_rst_n |=> core_rst_n);

endmodule

bind boot_seq_top boot_seq_chk chk_i (
    .clk            (clk),
    .rst_pin_n      (rst_pin_n),
    .host_wr        (host_wr),
    .host_start_bit (host_start_bit),
    .copy_done      (copy_done),
    .endian_le      (endian_le),
    .pll_mul4       (pll_mul4),
    .copy_start     (copy_start),
    .copy_width     (copy_width),
    .core_rst_n     (core_rst_n),
    .is_host        (is_host),
    .copy_busy      (copy_busy)
);

// File: tb/boot_seq_tb.sv
// Bench for boot_seq_top: random boot sequences from a fixed seed plus
// directed corner cases, with expected values from bench functions.
module boot_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic [1:0] strap_mode = 2'b00;
    logic       strap_endian = 1'b0;
    logic       strap_clkmul = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_start_bit = 1'b0;
    logic       copy_done = 1'b0;
    logic       endian_le, pll_mul4, copy_start, core_rst_n;
    logic [1:0] copy_width;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int seed_v;

    boot_seq_top dut_i (
        .clk(clk), .rst_pin_n(rst_pin_n), .strap_mode(strap_mode),
        .strap_endian(strap_endian), .strap_clkmul(strap_clkmul),
        .host_wr(host_wr), .host_start_bit(host_start_bit),
        .copy_done(copy_done), .endian_le(endian_le), .pll_mul4(pll_mul4),
        .copy_start(copy_start), .copy_width(copy_width),
        .core_rst_n(core_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_LIMIT) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WDOG_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic f_rom(input logic [1:0] m);
        return m != 2'b00;
    endfunction

    function automatic logic [1:0] f_width(input logic [1:0] m);
        return (m == 2'b00) ? 2'b11 : m - 2'b01;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks = n_checks + 1;
        if (act !== exp_v) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet_inputs();
        host_wr = 1'b0; host_start_bit = 1'b0; copy_done = 1'b0;
    endtask

    // Hold reset with given straps, release, check launch and captured straps.
    task automatic boot_up(input logic [1:0] m, input logic e, input logic k);
        quiet_inputs();
        rst_pin_n = 1'b0;
        strap_mode = m; strap_endian = e; strap_clkmul = k;
        step(); step();
        check("R1 core held in reset", core_rst_n, 1'b0);
        check("R1 no start in reset", copy_start, 1'b0);
        rst_pin_n = 1'b1;
        step();
        // Scramble straps right after the release edge.
        strap_mode = ~m; strap_endian = ~e; strap_clkmul = ~k;
        check("R4 R5 start pulse after release", copy_start, f_rom(m));
        check("R2 endian_le", endian_le, e);
        check("R2 pll_mul4", pll_mul4, k);
        check("R3 copy_width", copy_width, f_width(m));
        step();
        check("R4 start pulse single cycle", copy_start, 1'b0);
        check("R2 endian held", endian_le, e);
        check("R3 width held", copy_width, f_width(m));
    endtask

    // Drive ignored events, then the real one, then check release.
    task automatic finish_boot(input logic [1:0] m, input int noise);
        for (int i = 0; i < noise; i++) begin
            if (f_rom(m)) begin
                host_wr = 1'b1; host_start_bit = $urandom_range(0, 1);
            end else begin
                copy_done = 1'b1;
                host_wr = $urandom_range(0, 1); host_start_bit = 1'b0;
            end
            step();
            check("R8 R7 ignored event keeps core held", core_rst_n, 1'b0);
            check("R5 no start later", copy_start, 1'b0);
        end
        quiet_inputs();
        if (f_rom(m)) copy_done = 1'b1;
        else begin host_wr = 1'b1; host_start_bit = 1'b1; end
        step();
        quiet_inputs();
        check(f_rom(m) ? "R6 release on copy_done" : "R7 release on host start", core_rst_n, 1'b1);
        copy_done = 1'b1; host_wr = 1'b1; host_start_bit = 1'b1;
        step(); step();
        quiet_inputs();
        check("R9 core stays released", core_rst_n, 1'b1);
    endtask

    initial begin
        seed_v = 32'h5eed_0b07;
        void'($urandom(seed_v));
        step();

        // Directed: each mode, every strap combination once.
        for (int m = 0; m < 4; m++) begin
            boot_up(m[1:0], m[0], m[1]);
            finish_boot(m[1:0], 2);
        end

        // Directed R10: no event for a long while, in each flow.
        boot_up(2'b10, 1'b1, 1'b0);
        repeat (50) step();
        check("R10 ROM mode stays held without copy_done", core_rst_n, 1'b0);
        boot_up(2'b00, 1'b0, 1'b1);
        repeat (50) step();
        check("R10 host mode stays held without start", core_rst_n, 1'b0);

        // Directed R9: reset mid-copy, reboot in another mode.
        boot_up(2'b11, 1'b0, 1'b0);
        boot_up(2'b00, 1'b1, 1'b1);
        finish_boot(2'b00, 1);

        // Directed R7: host start accepted at the release edge itself.
        quiet_inputs();
        rst_pin_n = 1'b0; strap_mode = 2'b00;
        step(); step();
        rst_pin_n = 1'b1; host_wr = 1'b1; host_start_bit = 1'b1;
        step();
        quiet_inputs();
        check("R7 host start at release edge", core_rst_n, 1'b1);
        check("R5 host mode no start", copy_start, 1'b0);

        // Random sequences.
        for (int t = 0; t < 40; t++) begin
            logic [1:0] rm;
            rm = 2'($urandom_range(0, 3));
            boot_up(rm, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            finish_boot(rm, $urandom_range(0, 5));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule